// File: doc/BRIEF.md
# Programmable Event Counter Pair

This block holds two 40-bit performance-monitoring counters. Each cycle, a bank of eight event sources supplies small 3-bit counts. Each counter picks one source with an 8-bit event code and an 8-bit unit-mask code. It then filters that count by privilege level and by a count-mask threshold, which can be inverted. The result is either accumulated directly or reduced to a single rising-edge event. Two sources are bound to one counter each. Divider-busy cycles belong to counter 0, and the multiply/divide operation count belongs to counter 1. Programming either of them on the other counter yields nothing.

Software reaches the block through a flat register port. Writes happen on `reg_wr`, and reads are combinational through `reg_rdata`. Every counter has one configuration word and a value split into a low word and a high word. One shared status word holds the sticky overflow bits, which are cleared by writing 1. An interrupt line is driven while any overflow bit is set on a counter whose interrupt enable is on.

Each counter has a three-state edge-history machine. `HS_OFF` is the state while the counter is disabled, and its history is cleared. `HS_ARMED` means the qualified condition was false in the last enabled cycle. `HS_HELD` means it was true. The transitions are as follows:
- **off-to-armed**: enabled and condition false.
- **off-to-held**: enabled and condition true.
- **armed-to-held**: condition rises.
- **held-to-armed**: condition falls.
- **any-to-off**: enable cleared.

An edge increment fires when the condition is true in `HS_OFF` or `HS_ARMED`.

Top module: `evt_pair_counter`

## Requirements
- R1: The block has two 40-bit counters. Both reset to zero. The register addresses are:
  - 3k: configuration of counter k.
  - 3k+1: counter k bits 31:0.
  - 3k+2: counter k bits 39:32, in data bits 7:0.
  - 6: status.

  Each counter half is writable and reads back what was written.
- R2: The configuration word has these fields:
  - bits 7:0: event code.
  - bits 15:8: unit mask.
  - bits 23:16: count mask.
  - bit 24: user enable.
  - bit 25: kernel enable.
  - bit 26: edge mode.
  - bit 27: invert.
  - bit 28: interrupt enable.
  - bit 31: counter enable.

  With a zero count mask and edge mode off, an enabled counter adds the full selected 3-bit count every cycle, and invert has no effect.
- R3: With a nonzero count mask and no invert, the counter adds 1 in each cycle where the selected count is greater than or equal to the mask.
- R4: With a nonzero count mask and invert set, the counter adds 1 in each cycle where the selected count is less than the mask.
- R5: In edge mode the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous enabled cycle. The condition is the threshold compare, or count nonzero when the mask is zero.
- R6: With the user enable, the counter counts only while `priv_lvl` is 1 to 3. With the kernel enable, it counts only while `priv_lvl` is 0. With neither enable set, it counts at every level.
- R7: Event code 0x3C with unit mask u < 6 selects source u, which occupies bits 3u+2:3u of `evt_bus`. Any other code or mask combination selects nothing, except those in R8.
- R8: Code 0x14 with mask 0 selects source 6, and only on counter 0. Code 0x13 with mask 0 selects source 7, and only on counter 1. On the other counter, either code counts nothing.
- R9: While its enable is clear, a counter holds its value and its edge history is cleared. A condition that is still true on re-enable therefore counts once more.
- R10: A counter that wraps past all ones sets its bit k in status, and the bit stays set. Writing 1 to status bit k clears it, and writing 0 leaves it.
- R11: `irq` is high while any counter has both its status bit and its interrupt enable set.
- R12: A software write to a counter half replaces the increment in that cycle, and it never sets the overflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| priv_lvl | input | 2 | Current privilege level, 0 = kernel |
| evt_bus | input | 24 | Eight 3-bit per-cycle event counts |
| irq | output | 1 | Overflow interrupt |

## Verification
The checker watches several properties every cycle:
- A disabled counter holds its value.
- In edge mode, or with a threshold, a counter never moves by more than one per cycle.
- A restricted event on the wrong counter leaves that counter frozen.
- The overflow bits stay set until they are cleared.
- A write to a counter half lands exactly.
- `irq` tracks an enabled overflow bit.

Some behaviour only shows up in the bench's scenarios, which compare against a reference model. This covers the exact threshold and invert arithmetic, the privilege filter and the source decoding. It also covers the extra count on re-enable, the wrap value itself, and randomly mixed configurations.

// File: rtl/evp_pkg.sv
`timescale 1ns/1ps
package evp_pkg;
    localparam int REG_DW = 32;

    localparam logic [7:0] EVT_GENERIC  = 8'h3C;
    localparam logic [7:0] EVT_DIV_BUSY = 8'h14;
    localparam logic [7:0] EVT_MULDIV   = 8'h13;

    typedef struct packed {
        logic       en;
        logic [1:0] spare;
        logic       irq_en;
        logic       inv;
        logic       edge_md;
        logic       os_en;
        logic       usr_en;
        logic [7:0] cmask;
        logic [7:0] umask;
        logic [7:0] evsel;
    } ctr_cfg_t;

    typedef enum logic [1:0] {
        HS_OFF   = 2'd0,
        HS_ARMED = 2'd1,
        HS_HELD  = 2'd2
    } hist_state_e;
endpackage

// File: rtl/evp_event_select.sv
`timescale 1ns/1ps
module evp_event_select
    import evp_pkg::*;
#(
    parameter int CTR_IDX = 0,
    parameter int NSRC    = 8,
    parameter int CW      = 3
) (
    input  logic [7:0]         evsel,
    input  logic [7:0]         umask,
    input  logic [NSRC*CW-1:0] evt_bus,
    output logic               sel_ok,
    output logic [CW-1:0]      sel_cnt
);
    localparam int NGEN    = NSRC - 2;
    localparam int DIV_SRC = NSRC - 2;
    localparam int MUL_SRC = NSRC - 1;

    int idx;

    always_comb begin
        sel_ok = 1'b0;
        idx    = 0;
        if (evsel == EVT_GENERIC && int'(umask) < NGEN) begin
            sel_ok = 1'b1;
            idx    = int'(umask);
        end else if (evsel == EVT_DIV_BUSY && umask == 8'h00 && CTR_IDX == 0) begin
            sel_ok = 1'b1;
            idx    = DIV_SRC;
        end else if (evsel == EVT_MULDIV && umask == 8'h00 && CTR_IDX == 1) begin
            sel_ok = 1'b1;
            idx    = MUL_SRC;
        end
    end

    always_comb begin
        sel_cnt = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (sel_ok && idx == s) sel_cnt = evt_bus[s*CW +: CW];
        end
    end
endmodule

// File: rtl/evp_counter_slice.sv
`timescale 1ns/1ps
module evp_counter_slice
    import evp_pkg::*;
#(
    parameter  int CTR_W = 40,
    parameter  int CW    = 3,
    localparam int HI_W  = CTR_W - REG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              edge_md,
    input  logic              inv,
    input  logic              usr_en,
    input  logic              os_en,
    input  logic [7:0]        cmask,
    input  logic              sel_ok,
    input  logic [CW-1:0]     sel_cnt,
    input  logic [1:0]        priv_lvl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [REG_DW-1:0] wdata,
    output logic [CTR_W-1:0]  value,
    output logic              wrap
);
    hist_state_e st_q, st_d;

    logic            priv_ok;
    logic            qual;
    logic            cond;
    logic            edge_fire;
    logic [CW-1:0]   step;
    logic [7:0]      cnt8;
    logic [CTR_W:0]  sum;
    logic [CTR_W-1:0] value_q;

    always_comb begin
        priv_ok = (!usr_en && !os_en) || ((priv_lvl == 2'd0) ? os_en : usr_en);
        qual    = sel_ok && priv_ok;
        cnt8    = 8'(sel_cnt);
        if (cmask != 8'd0)
            cond = qual && (inv ? (cnt8 < cmask) : (cnt8 >= cmask));
        else
            cond = qual && (sel_cnt != '0);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HS_OFF;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = HS_OFF;
        unique case (st_q)
            HS_OFF:   st_d = cond ? HS_HELD : HS_ARMED;
            HS_ARMED: st_d = cond ? HS_HELD : HS_ARMED;
            HS_HELD:  st_d = cond ? HS_HELD : HS_ARMED;
            default:  st_d = HS_OFF;
        endcase
        if (!en) st_d = HS_OFF;
    end

    // output logic
    always_comb begin
        edge_fire = 1'b0;
        unique case (st_q)
            HS_OFF, HS_ARMED: edge_fire = cond;
            HS_HELD:          edge_fire = 1'b0;
            default:          edge_fire = 1'b0;
        endcase
        if (!en)                 step = '0;
        else if (edge_md)        step = CW'(edge_fire);
        else if (cmask != 8'd0)  step = CW'(cond);
        else                     step = qual ? sel_cnt : '0;
    end

    assign sum  = {1'b0, value_q} + (CTR_W+1)'(step);
    assign wrap = en && !(wr_lo || wr_hi) && sum[CTR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) value_q[REG_DW-1:0]     <= wdata;
            if (wr_hi) value_q[CTR_W-1:REG_DW] <= wdata[HI_W-1:0];
        end else if (en) begin
            value_q <= sum[CTR_W-1:0];
        end
    end

    assign value = value_q;
endmodule

// File: rtl/evt_pair_counter.sv
`timescale 1ns/1ps
module evt_pair_counter
    import evp_pkg::*;
#(
    parameter  int NUM_CTR = 2,
    parameter  int CTR_W   = 40,
    parameter  int NSRC    = 8,
    parameter  int CW      = 3,
    localparam int AW      = $clog2(3*NUM_CTR+1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    input  logic [1:0]         priv_lvl,
    input  logic [NSRC*CW-1:0] evt_bus,
    output logic               irq
);
    localparam logic [AW-1:0] STAT_ADDR = AW'(3*NUM_CTR);

    ctr_cfg_t [NUM_CTR-1:0]            cfg_q;
    logic     [NUM_CTR-1:0][CTR_W-1:0] ctr_val;
    logic     [NUM_CTR-1:0]            ovf_q;
    logic     [NUM_CTR-1:0]            wrap_v;
    logic     [NUM_CTR-1:0]            en_v, edge_v, ie_v;
    logic     [NUM_CTR-1:0][7:0]       cmask_v, evsel_v, umask_v;
    logic                              stat_wr;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic          cfg_wr, lo_wr, hi_wr;
        logic          sel_ok;
        logic [CW-1:0] sel_cnt;

        assign cfg_wr = reg_wr && reg_addr == AW'(3*g);
        assign lo_wr  = reg_wr && reg_addr == AW'(3*g+1);
        assign hi_wr  = reg_wr && reg_addr == AW'(3*g+2);

        always_ff @(posedge clk) begin
            if (!rst_n)      cfg_q[g] <= '0;
            else if (cfg_wr) cfg_q[g] <= ctr_cfg_t'(reg_wdata);
        end

        assign en_v[g]    = cfg_q[g].en;
        assign edge_v[g]  = cfg_q[g].edge_md;
        assign ie_v[g]    = cfg_q[g].irq_en;
        assign cmask_v[g] = cfg_q[g].cmask;
        assign evsel_v[g] = cfg_q[g].evsel;
        assign umask_v[g] = cfg_q[g].umask;

        evp_event_select #(.CTR_IDX(g), .NSRC(NSRC), .CW(CW)) u_sel (
            .evsel   (cfg_q[g].evsel),
            .umask   (cfg_q[g].umask),
            .evt_bus (evt_bus),
            .sel_ok  (sel_ok),
            .sel_cnt (sel_cnt)
        );

        evp_counter_slice #(.CTR_W(CTR_W), .CW(CW)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cfg_q[g].en),
            .edge_md  (cfg_q[g].edge_md),
            .inv      (cfg_q[g].inv),
            .usr_en   (cfg_q[g].usr_en),
            .os_en    (cfg_q[g].os_en),
            .cmask    (cfg_q[g].cmask),
            .sel_ok   (sel_ok),
            .sel_cnt  (sel_cnt),
            .priv_lvl (priv_lvl),
            .wr_lo    (lo_wr),
            .wr_hi    (hi_wr),
            .wdata    (reg_wdata),
            .value    (ctr_val[g]),
            .wrap     (wrap_v[g])
        );
    end

    assign stat_wr = reg_wr && reg_addr == STAT_ADDR;

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= (ovf_q & ~(stat_wr ? reg_wdata[NUM_CTR-1:0] : '0)) | wrap_v;
    end

    assign irq = |(ovf_q & ie_v);

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (reg_addr == AW'(3*k))   reg_rdata = REG_DW'(cfg_q[k]);
            if (reg_addr == AW'(3*k+1)) reg_rdata = ctr_val[k][REG_DW-1:0];
            if (reg_addr == AW'(3*k+2)) reg_rdata = REG_DW'(ctr_val[k][CTR_W-1:REG_DW]);
        end
        if (reg_addr == STAT_ADDR) reg_rdata = REG_DW'(ovf_q);
    end
endmodule

// File: rtl/evt_pair_counter_chk.sv
`timescale 1ns/1ps
module evt_pair_counter_chk
    import evp_pkg::*;
#(
    parameter int NUM_CTR = 2,
    parameter int CTR_W   = 40,
    parameter int AW      = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [AW-1:0]                 reg_addr,
    input logic [REG_DW-1:0]             reg_wdata,
    input logic                          irq,
    input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_val,
    input logic [NUM_CTR-1:0]            ovf_q,
    input logic [NUM_CTR-1:0]            en_v,
    input logic [NUM_CTR-1:0]            edge_v,
    input logic [NUM_CTR-1:0]            ie_v,
    input logic [NUM_CTR-1:0][7:0]       cmask_v,
    input logic [NUM_CTR-1:0][7:0]       evsel_v,
    input logic [NUM_CTR-1:0][7:0]       umask_v
);
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
        logic val_wr, clr_me;
        assign val_wr = reg_wr && (reg_addr == AW'(3*g+1) || reg_addr == AW'(3*g+2));
        assign clr_me = reg_wr && reg_addr == AW'(3*NUM_CTR) && reg_wdata[g];

        p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[g] && !val_wr) |=> ctr_val[g] == $past(ctr_val[g]));

        p_edge_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[g] && edge_v[g] && !val_wr) |=>
            (ctr_val[g] == $past(ctr_val[g]) || ctr_val[g] == $past(ctr_val[g]) + CTR_W'(1)));

        p_thresh_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[g] && cmask_v[g] != 8'd0 && !val_wr) |=>
            (ctr_val[g] == $past(ctr_val[g]) || ctr_val[g] == $past(ctr_val[g]) + CTR_W'(1)));

        if (g == 0) begin : g_r0
            p_wrong_ctr_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (evsel_v[g] == EVT_MULDIV && umask_v[g] == 8'h00 && !val_wr) |=>
                ctr_val[g] == $past(ctr_val[g]));
        end else if (g == 1) begin : g_r1
            p_wrong_ctr_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (evsel_v[g] == EVT_DIV_BUSY && umask_v[g] == 8'h00 && !val_wr) |=>
                ctr_val[g] == $past(ctr_val[g]));
        end

        p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[g] && !clr_me) |=> ovf_q[g]);

        p_irq_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[g] && ie_v[g]) |-> irq);

        p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == AW'(3*g+1)) |=>
            ctr_val[g][REG_DW-1:0] == $past(reg_wdata));
    end
endmodule

bind evt_pair_counter evt_pair_counter_chk #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .ctr_val   (ctr_val),
    .ovf_q     (ovf_q),
    .en_v      (en_v),
    .edge_v    (edge_v),
    .ie_v      (ie_v),
    .cmask_v   (cmask_v),
    .evsel_v   (evsel_v),
    .umask_v   (umask_v)
);

// File: tb/evt_pair_counter_bench.sv
`timescale 1ns/1ps
module evt_pair_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  priv_lvl = '0;
    logic [23:0] evt_bus = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    bit [39:0] m_val [2];
    bit [31:0] m_cfg [2];
    bit        m_hist[2];
    bit [1:0]  m_ovf;

    always #10 clk = ~clk;

    evt_pair_counter u_evt_pair_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_lvl(priv_lvl),
        .evt_bus(evt_bus), .irq(irq)
    );

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // reference model of one counter for one cycle
    function automatic void eval_ctr(input bit [31:0] c, input int k, input bit [23:0] ev,
                                     input bit [1:0] pl, input bit prev,
                                     output int inc, output bit cnd);
        bit [7:0] es, um, cm;
        bit ok, pok;
        int src, n;
        es = c[7:0]; um = c[15:8]; cm = c[23:16];
        ok = 0; src = 0;
        if (es == 8'h3C && um < 8'd6) begin ok = 1; src = int'(um); end
        else if (es == 8'h14 && um == 0 && k == 0) begin ok = 1; src = 6; end
        else if (es == 8'h13 && um == 0 && k == 1) begin ok = 1; src = 7; end
        n = ok ? int'(ev[src*3 +: 3]) : 0;
        pok = (!c[24] && !c[25]) || (pl == 0 ? c[25] : c[24]);
        ok = ok && pok;
        if (cm != 0) cnd = ok && (c[27] ? (n < int'(cm)) : (n >= int'(cm)));
        else         cnd = ok && (n != 0);
        if (!c[31])        inc = 0;
        else if (c[26])    inc = (cnd && !prev) ? 1 : 0;
        else if (cm != 0)  inc = cnd ? 1 : 0;
        else               inc = ok ? n : 0;
    endfunction

    task automatic step();
        bit [39:0] nv [2];
        bit [31:0] nc [2];
        bit        nh [2];
        bit [1:0]  nov;
        nov = m_ovf;
        if (reg_wr && reg_addr == 3'd6) nov = nov & ~reg_wdata[1:0];
        for (int k = 0; k < 2; k++) begin
            int inc; bit cnd; bit [40:0] s;
            eval_ctr(m_cfg[k], k, evt_bus, priv_lvl, m_hist[k], inc, cnd);
            s = {1'b0, m_val[k]} + 41'(inc);
            nv[k] = s[39:0];
            nh[k] = m_cfg[k][31] ? cnd : 1'b0;
            nc[k] = m_cfg[k];
            if (reg_wr && reg_addr == 3'(3*k+1)) nv[k] = {m_val[k][39:32], reg_wdata};
            else if (reg_wr && reg_addr == 3'(3*k+2)) nv[k] = {reg_wdata[7:0], m_val[k][31:0]};
            else if (m_cfg[k][31] && s[40]) nov[k] = 1'b1;
            if (reg_wr && reg_addr == 3'(3*k)) nc[k] = reg_wdata;
        end
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            m_val[k] = nv[k]; m_cfg[k] = nc[k]; m_hist[k] = nh[k];
        end
        m_ovf = nov;
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit [2:0] a, output bit [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_ctr(input int k, input string tag);
        bit [31:0] lo, hi;
        bit [39:0] got;
        rd(3'(3*k+1), lo);
        rd(3'(3*k+2), hi);
        got = {hi[7:0], lo};
        n_chk++;
        if (got !== m_val[k] || hi[31:8] != 0) begin
            n_bad++;
            $display("FAIL %s counter%0d: actual=%h expected=%h", tag, k, {hi, lo}, m_val[k]);
        end
    endtask

    task automatic check_lit(input int k, input bit [39:0] exp, input string tag);
        n_chk++;
        if (m_val[k] !== exp) begin
            n_bad++;
            $display("FAIL %s model counter%0d: actual=%h expected=%h", tag, k, m_val[k], exp);
        end
        check_ctr(k, tag);
    endtask

    task automatic check_stat(input string tag);
        bit [31:0] s;
        bit exp_irq;
        rd(3'd6, s);
        exp_irq = |(m_ovf & {m_cfg[1][28], m_cfg[0][28]});
        n_chk++;
        if (s !== {30'd0, m_ovf} || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s status: actual=%h/irq%0b expected=%h/irq%0b",
                     tag, s, irq, {30'd0, m_ovf}, exp_irq);
        end
    endtask

    task automatic ev1(input int src, input int n);
        evt_bus = '0;
        evt_bus[src*3 +: 3] = 3'(n);
    endtask

    task automatic clear_both();
        evt_bus = '0;
        wr(3'd0, 0); wr(3'd3, 0);
        wr(3'd1, 0); wr(3'd2, 0); wr(3'd4, 0); wr(3'd5, 0);
    endtask

    initial begin
        bit [31:0] r;
        void'($urandom(32'd20250611));
        for (int k = 0; k < 2; k++) begin
            m_val[k] = 0; m_cfg[k] = 0; m_hist[k] = 0;
        end
        m_ovf = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset and read/write of both halves
        check_lit(0, 40'd0, "R1");
        check_lit(1, 40'd0, "R1");
        check_stat("R1");
        wr(3'd1, 32'h3456789A); wr(3'd2, 32'h12);
        check_lit(0, 40'h123456789A, "R1");
        wr(3'd4, 32'hCAFEF00D); wr(3'd5, 32'hA5);
        check_lit(1, 40'hA5CAFEF00D, "R1");
        clear_both();

        // R2 full count with zero mask; invert ignored on counter 1
        wr(3'd0, 32'h8000_023C); wr(3'd3, 32'h8800_023C);
        repeat (3) begin ev1(2, 5); step(); end
        ev1(2, 0); step();
        check_lit(0, 40'd15, "R2");
        check_lit(1, 40'd15, "R2");

        // R3 threshold
        clear_both();
        wr(3'd0, 32'h8003_023C);
        foreach (r[i]) if (i < 4) begin ev1(2, (i==0)?2:(i==1)?3:(i==2)?7:0); step(); end
        evt_bus = '0;
        check_lit(0, 40'd2, "R3");

        // R4 inverted threshold
        wr(3'd3, 32'h8803_023C);
        for (int i = 0; i < 5; i++) begin ev1(2, (i==0)?2:(i==1)?3:(i==2)?7:(i==3)?0:1); step(); end
        evt_bus = '0;
        check_lit(1, 40'd3, "R4");

        // R5 edge mode
        clear_both();
        wr(3'd0, 32'h8400_033C);
        for (int i = 0; i < 8; i++) begin
            ev1(3, (i==0||i==1||i==7) ? 1 : (i==2||i==6) ? 0 : 2);
            step();
        end
        evt_bus = '0; step();
        check_lit(0, 40'd3, "R5");

        // R6 privilege filtering
        foreach (r[j]) if (j < 3) begin
            clear_both();
            wr(3'd0, (j==0) ? 32'h8100_013C : (j==1) ? 32'h8200_013C : 32'h8000_013C);
            priv_lvl = 0; ev1(1, 2); step();
            priv_lvl = 3; ev1(1, 2); step();
            priv_lvl = 1; ev1(1, 1); step();
            evt_bus = '0; priv_lvl = 0;
            check_lit(0, (j==0) ? 40'd3 : (j==1) ? 40'd2 : 40'd5, "R6");
        end

        // R7 bad unit mask and unknown code select nothing
        clear_both();
        wr(3'd0, 32'h8000_063C); wr(3'd3, 32'h8000_0055);
        repeat (3) begin evt_bus = 24'hFFFFFF; step(); end
        evt_bus = '0;
        check_lit(0, 40'd0, "R7");
        check_lit(1, 40'd0, "R7");

        // R8 restricted events
        wr(3'd0, 32'h8000_0013); wr(3'd3, 32'h8000_0013);
        repeat (4) begin evt_bus = 24'hDB6DB6 & 24'hFFFFFF; evt_bus = {8{3'd3}}; step(); end
        evt_bus = '0;
        check_lit(0, 40'd0, "R8");
        check_lit(1, 40'd12, "R8");
        wr(3'd0, 32'h8000_0014); wr(3'd3, 32'h8000_0014);
        repeat (2) begin evt_bus = {8{3'd2}}; step(); end
        evt_bus = '0;
        check_lit(0, 40'd4, "R8");
        check_lit(1, 40'd12, "R8");

        // R9 disable holds and clears history
        clear_both();
        wr(3'd0, 32'h8400_003C);
        ev1(0, 1);
        repeat (3) step();
        wr(3'd0, 32'h0400_003C);
        repeat (3) step();
        check_lit(0, 40'd1, "R9");
        wr(3'd0, 32'h8400_003C);
        repeat (2) step();
        evt_bus = '0;
        check_lit(0, 40'd2, "R9");

        // R10 / R11 wrap, sticky status, interrupt, clear
        clear_both();
        wr(3'd0, 32'h9000_003C); wr(3'd1, 32'hFFFF_FFFE); wr(3'd2, 32'hFF);
        ev1(0, 3); step(); evt_bus = '0;
        check_lit(0, 40'd1, "R10");
        check_stat("R10");
        n_chk++;
        if (irq !== 1'b1) begin n_bad++; $display("FAIL R11 irq: actual=%0b expected=1", irq); end
        step(); step();
        check_stat("R10");
        wr(3'd6, 32'h2);
        check_stat("R10");
        wr(3'd6, 32'h1);
        check_stat("R11");
        wr(3'd3, 32'h8000_003C); wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFF);
        ev1(0, 1); step(); evt_bus = '0;
        check_stat("R11");
        check_lit(1, 40'd0, "R10");
        wr(3'd6, 32'h3);

        // R12 write beats increment
        clear_both();
        wr(3'd0, 32'h8000_003C);
        ev1(0, 2);
        step();
        wr(3'd1, 32'h100);
        evt_bus = '0;
        check_lit(0, 40'h100, "R12");
        ev1(0, 2); step(); evt_bus = '0;
        check_lit(0, 40'h102, "R12");

        // random mixed configurations
        for (int rnd = 0; rnd < 40; rnd++) begin
            for (int k = 0; k < 2; k++) begin
                bit [31:0] c;
                int pick;
                c = $urandom;
                pick = $urandom_range(3, 0);
                c[7:0]   = (pick==0) ? 8'h3C : (pick==1) ? 8'h14 : (pick==2) ? 8'h13 : 8'h55;
                c[15:8]  = 8'($urandom_range(7, 0));
                c[23:16] = ($urandom_range(1, 0) != 0) ? 8'($urandom_range(7, 0)) : 8'd0;
                c[31]    = ($urandom_range(3, 0) != 0);
                wr(3'(3*k), c);
                if ($urandom_range(3, 0) == 0) begin
                    wr(3'(3*k+2), 32'hFF);
                    wr(3'(3*k+1), 32'hFFFF_FFF0);
                end
            end
            for (int cyc = 0; cyc < 40; cyc++) begin
                evt_bus  = 24'($urandom);
                priv_lvl = 2'($urandom);
                step();
            end
            evt_bus = '0;
            check_ctr(0, "R2 R3 R4 R5 R6 R7 R8 random");
            check_ctr(1, "R2 R3 R4 R5 R6 R7 R8 random");
            check_stat("R10 R11 random");
            wr(3'd6, 32'h3);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule